// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the datapath of a small 32-bit processor that runs one instruction over several short clock cycles. A single ALU and a single memory port serve every step of every instruction. The intermediate results are held in working registers between steps: the instruction word, the two register operands, the ALU result and the memory read word. The supported steps cover register-to-register arithmetic, word loads and stores, equal-compare branches and absolute jumps.

The block makes no decisions of its own. An external sequencer drives every enable and multiplexer select in each cycle. The datapath returns the current opcode and an ALU zero flag, which the sequencer uses to choose its next step and to decide whether a branch is taken.

Memory is outside the block. It presents a word address, write data and a write strobe, and it expects the read word back in the same cycle.

Top module: `mc_datapath`

## Requirements
- R1: After reset the program counter is 0x00400000, the instruction register is zero, and with `iord`=0 the memory address equals the program counter.
- R2: The instruction register loads `mem_rdata` only at an edge with `ir_write`=1, and the program counter changes only at an edge with `pc_write`=1. `opcode` shows instruction bits [31:26].
- R3: With `iord`=1 the memory address is the latched ALU result. `mem_wdata` is the B operand register and `mem_we` follows `mem_write`.
- R4: `alu_ctl` encodings are 010 add, 110 subtract, 000 AND, 001 OR and 111 signed set-less-than (result 1 or 0). Any other code gives 0. `zero` is 1 exactly when the ALU result is 0.
- R5: `alu_src_a`=0 selects the program counter and 1 selects operand register A. `alu_src_b` selects 0 operand register B, 1 the constant 4, 2 the sign-extended immediate, and 3 the sign-extended immediate shifted left by 2.
- R6: The register write address is instruction bits [15:11] when `reg_dst`=1 and bits [20:16] when 0. The write data is the memory data register when `mem_to_reg`=1 and the latched ALU result when 0.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: `pc_src` selects 0 the live ALU result, 1 the latched ALU result, 2 the jump target {PC[31:28], instruction[25:0], 00}, and 3 the live ALU result.
- R9: Operand registers A and B load at every edge from the registers named by instruction bits [25:21] and [20:16]. A register write and an operand load of the same register at one edge give the operand the old value. The new value appears one edge later.
- R10: The immediate in instruction bits [15:0] is sign-extended, so negative offsets give lower load/store addresses and backward branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_write | input | 1 | Program counter load enable |
| ir_write | input | 1 | Instruction register load enable |
| iord | input | 1 | Memory address select: 0 program counter, 1 latched ALU result |
| mem_write | input | 1 | Memory write request |
| reg_write | input | 1 | Register file write enable |
| reg_dst | input | 1 | Write address select: 1 bits [15:11], 0 bits [20:16] |
| mem_to_reg | input | 1 | Write data select: 1 memory data register, 0 latched ALU result |
| alu_src_a | input | 1 | ALU first operand select |
| alu_src_b | input | 2 | ALU second operand select |
| alu_ctl | input | 3 | ALU operation code |
| pc_src | input | 2 | Program counter source select |
| mem_rdata | input | 32 | Memory read word, same cycle as address |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits [31:26] |
| zero | output | 1 | ALU result equals zero |

## Verification
The two functions that meet in one cycle are the register file write-back and the every-edge reload of the operand registers. When a load targets the same register that it uses as its base, both happen at the same edge. The bench provokes this with a load whose base and destination registers are the same. It then runs two extra address-compute cycles and reads the resulting addresses on the memory address port. The first address must be built from the old register value and the second from the freshly loaded one.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 16;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  function automatic logic [XLEN-1:0] alu_eval(alu_op_e op, logic [XLEN-1:0] a,
                                               logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] sext_imm(logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] jump_target(logic [XLEN-1:0] pc,
                                                  logic [XLEN-7:0] field);
    return {pc[XLEN-1:XLEN-4], field, 2'b00};
  endfunction
endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] regs [NREG];
  logic          wr_take;

  // writes to the hard-wired zero register are dropped
  assign wr_take = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_take) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_eval(alu_op_e'(op), a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcdp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000,
  parameter int          NREG     = 32,
  localparam int         RAW      = $clog2(NREG)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pc_write,
  input  logic        ir_write,
  input  logic        iord,
  input  logic        mem_write,
  input  logic        reg_write,
  input  logic        reg_dst,
  input  logic        mem_to_reg,
  input  logic        alu_src_a,
  input  logic [1:0]  alu_src_b,
  input  logic [2:0]  alu_ctl,
  input  logic [1:0]  pc_src,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  output logic [5:0]  opcode,
  output logic        zero
);
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
  logic [XLEN-1:0] imm_ext, imm_sh, op_a, op_b, alu_y, pc_next, jump_addr;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [RAW-1:0]  rf_wa, rs_f, rt_f, rd_f;

  // instruction fields
  assign rs_f      = ir_q[25:21];
  assign rt_f      = ir_q[20:16];
  assign rd_f      = ir_q[15:11];
  assign imm_ext   = sext_imm(ir_q[15:0]);
  assign imm_sh    = imm_ext << 2;
  assign jump_addr = jump_target(pc_q, ir_q[25:0]);
  assign opcode    = ir_q[31:26];

  // register file with write-back selection
  assign rf_wa = reg_dst ? rd_f : rt_f;
  assign rf_wd = mem_to_reg ? mdr_q : aluout_q;

  mcdp_regfile #(.DW(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .ra1(rs_f), .ra2(rt_f), .rd1(rf_rd1), .rd2(rf_rd2),
    .we(reg_write), .wa(rf_wa), .wd(rf_wd)
  );

  // operand selection
  assign op_a = alu_src_a ? a_q : pc_q;
  always_comb begin
    case (alu_src_b)
      2'd0:    op_b = b_q;
      2'd1:    op_b = 32'd4;
      2'd2:    op_b = imm_ext;
      default: op_b = imm_sh;
    endcase
  end

  mcdp_alu u_alu (.op(alu_ctl), .a(op_a), .b(op_b), .y(alu_y), .zero(zero));

  // next program counter
  always_comb begin
    case (pc_src)
      2'd1:    pc_next = aluout_q;
      2'd2:    pc_next = jump_addr;
      default: pc_next = alu_y;
    endcase
  end

  // enabled architectural registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_PC;
      ir_q <= '0;
    end else begin
      if (pc_write) pc_q <= pc_next;
      if (ir_write) ir_q <= mem_rdata;
    end
  end

  // free-running step registers
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_y;
      mdr_q    <= mem_rdata;
    end
  end

  // memory port
  assign mem_addr  = iord ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = mem_write;

  // checks
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !pc_write |=> $stable(pc_q));

  p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ir_write |=> $stable(ir_q));

  p_a_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
    (ir_q[25:21] == 5'd0) |=> (a_q == '0));

  p_jump_region_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_write && pc_src == 2'd2) |=>
      (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28])));

  p_seq_step_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_write && pc_src == 2'd0 && !alu_src_a && alu_src_b == 2'd1 && alu_ctl == 3'b010)
      |=> (pc_q == $past(pc_q) + 32'd4));
endmodule

// File: tb/tb_mc_datapath.sv
`timescale 1ns/1ps
module tb_mc_datapath;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic pc_write, ir_write, iord, mem_write, reg_write, reg_dst, mem_to_reg, alu_src_a;
  logic [1:0] alu_src_b, pc_src;
  logic [2:0] alu_ctl;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_we, zero;
  logic [5:0] opcode;

  mc_datapath dut (
    .clk(clk), .rst(rst), .pc_write(pc_write), .ir_write(ir_write), .iord(iord),
    .mem_write(mem_write), .reg_write(reg_write), .reg_dst(reg_dst),
    .mem_to_reg(mem_to_reg), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .alu_ctl(alu_ctl), .pc_src(pc_src), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .opcode(opcode), .zero(zero)
  );

  // bench memory: bench-written words plus design-written words
  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic        dval [256];
  assign mem_rdata = dval[mem_addr[9:2]] ? dmem[mem_addr[9:2]] : imem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) dval[i] <= 1'b0;
    end else if (mem_we) begin
      dmem[mem_addr[9:2]] <= mem_wdata;
      dval[mem_addr[9:2]] <= 1'b1;
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] mr [32];
  logic [31:0] pcm, cur;

  localparam logic [2:0] K_ADD = 3'b010, K_SUB = 3'b110, K_AND = 3'b000,
                         K_OR = 3'b001, K_SLT = 3'b111;

  function automatic logic [31:0] ref_alu(logic [2:0] k, logic [31:0] a, logic [31:0] b);
    if (k == K_ADD) return a + b;
    else if (k == K_SUB) return a - b;
    else if (k == K_AND) return a & b;
    else if (k == K_OR) return a | b;
    else if (k == K_SLT) return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    return 32'd0;
  endfunction

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // scoreboard monitor: compares every store against the queued expectation
  always @(negedge clk) begin
    logic [31:0] e;
    #1;
    if (!rst && mem_we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3 store data: got %h expected no store", mem_wdata);
      end else begin
        e = exp_q.pop_front();
        if (mem_wdata !== e) begin
          n_bad++;
          $display("FAIL R3/R4 store data: got %h expected %h", mem_wdata, e);
        end
      end
    end
  end

  task automatic ctl_idle();
    pc_write = 0; ir_write = 0; iord = 0; mem_write = 0; reg_write = 0;
    reg_dst = 0; mem_to_reg = 0; alu_src_a = 0; alu_src_b = 0; alu_ctl = 0; pc_src = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fetch(input logic [31:0] instr);
    imem[pcm[9:2]] = instr;
    cur = instr;
    ctl_idle(); ir_write = 1; pc_write = 1; alu_src_b = 2'd1; alu_ctl = K_ADD;
    tick();
    pcm = pcm + 32'd4;
  endtask

  task automatic decode();
    ctl_idle(); alu_src_b = 2'd3; alu_ctl = K_ADD;
    #1;
    chk("R8 sequential pc", mem_addr, pcm);
    chk("R2 opcode", {26'd0, opcode}, {26'd0, cur[31:26]});
    tick();
  endtask

  task automatic addr_step();
    ctl_idle(); alu_src_a = 1; alu_src_b = 2'd2; alu_ctl = K_ADD;
    tick();
  endtask

  task automatic do_lw(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    logic [31:0] ea;
    fetch({6'h23, rs, rt, imm});
    decode();
    addr_step();
    ea = mr[rs] + sx(imm);
    ctl_idle(); iord = 1;
    #1 chk("R10 load address", mem_addr, ea);
    tick();
    ctl_idle(); reg_write = 1; mem_to_reg = 1;
    tick();
    if (rt != 0) mr[rt] = imem[ea[9:2]];
  endtask

  task automatic do_sw(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    fetch({6'h2b, rs, rt, imm});
    decode();
    addr_step();
    ctl_idle(); iord = 1; mem_write = 1;
    exp_q.push_back(mr[rt]);
    #1 chk("R3 store address", mem_addr, mr[rs] + sx(imm));
    tick();
    ctl_idle();
  endtask

  task automatic do_r(input logic [2:0] k, input logic [4:0] rs, input logic [4:0] rt,
                      input logic [4:0] rd);
    fetch({6'd0, rs, rt, rd, 5'd0, 6'h20});
    decode();
    ctl_idle(); alu_src_a = 1; alu_ctl = k;
    tick();
    ctl_idle(); reg_write = 1; reg_dst = 1;
    tick();
    if (rd != 0) mr[rd] = ref_alu(k, mr[rs], mr[rt]);
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    logic ez;
    fetch({6'h04, rs, rt, imm});
    decode();
    ctl_idle(); alu_src_a = 1; alu_ctl = K_SUB; pc_src = 2'd1;
    #1;
    ez = (mr[rs] == mr[rt]);
    chk("R4 zero flag", {31'd0, zero}, {31'd0, ez});
    pc_write = zero;
    tick();
    if (ez) pcm = pcm + (sx(imm) << 2);
    ctl_idle();
    #1 chk("R8/R10 branch pc", mem_addr, pcm);
  endtask

  task automatic do_j(input logic [25:0] t);
    fetch({6'h02, t});
    decode();
    ctl_idle(); pc_src = 2'd2; pc_write = 1;
    tick();
    pcm = {pcm[31:28], t, 2'b00};
    ctl_idle();
    #1 chk("R8 jump pc", mem_addr, pcm);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    ctl_idle();
    for (int i = 0; i < 256; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) mr[i] = 32'd0;
    imem[64] = 32'h0000_0007;
    imem[65] = 32'hFFFF_FFF0;
    imem[66] = 32'h1234_5678;
    imem[67] = 32'h0000_0120;
    pcm = 32'h0040_0000;
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 reset pc", mem_addr, 32'h0040_0000);
    chk("R1 reset ir", {26'd0, opcode}, 32'd0);
    chk("R3 idle strobe", {31'd0, mem_we}, 32'd0);
    @(negedge clk);

    // loads through rt destination (R6, R10)
    do_lw(5'd0, 5'd1, 16'h0100);
    do_lw(5'd0, 5'd2, 16'h0104);
    do_lw(5'd0, 5'd3, 16'h0108);
    do_lw(5'd0, 5'd12, 16'h010C);

    // ALU operations, each read back through a store (R4, R5, R6)
    do_r(K_ADD, 5'd1, 5'd2, 5'd4);  do_sw(5'd0, 5'd4, 16'h0110);
    do_r(K_SUB, 5'd1, 5'd2, 5'd5);  do_sw(5'd12, 5'd5, 16'hFFF8);  // R10 negative offset
    do_r(K_AND, 5'd3, 5'd2, 5'd6);  do_sw(5'd0, 5'd6, 16'h011C);
    do_r(K_OR,  5'd3, 5'd1, 5'd7);  do_sw(5'd0, 5'd7, 16'h0120);
    do_r(K_SLT, 5'd2, 5'd1, 5'd8);  do_sw(5'd0, 5'd8, 16'h0124);
    do_r(K_SLT, 5'd1, 5'd2, 5'd9);  do_sw(5'd0, 5'd9, 16'h0128);
    do_r(K_ADD, 5'd1, 5'd1, 5'd10);
    do_r(3'b011, 5'd1, 5'd2, 5'd10); do_sw(5'd0, 5'd10, 16'h012C); // R4 unused code
    // R7: write to register 0 discarded
    do_r(K_ADD, 5'd1, 5'd1, 5'd0);  do_sw(5'd0, 5'd0, 16'h0130);

    // branches (R4 zero, R8 latched target, R10 backward)
    do_beq(5'd1, 5'd1, 16'd3);
    do_beq(5'd1, 5'd2, 16'd5);
    do_beq(5'd2, 5'd2, 16'hFFFE);
    do_j(26'h30);

    // R2: no enables, PC and IR hold while memory shows a different word
    imem[pcm[9:2]] = 32'h8C00_0000;
    ctl_idle(); alu_src_b = 2'd1; alu_ctl = K_ADD;
    tick();
    #1;
    chk("R2 pc hold", mem_addr, pcm);
    chk("R2 ir hold", {26'd0, opcode}, {26'd0, cur[31:26]});

    // R8: select code 3 takes the live ALU result
    ctl_idle(); pc_write = 1; pc_src = 2'd3; alu_src_b = 2'd1; alu_ctl = K_ADD;
    tick();
    pcm = pcm + 32'd4;
    ctl_idle();
    #1 chk("R8 select 3", mem_addr, pcm);

    // R9: write-back and operand reload of the same register at one edge
    do_lw(5'd13, 5'd13, 16'h0100);
    addr_step();
    ctl_idle(); iord = 1; alu_src_a = 1; alu_src_b = 2'd2; alu_ctl = K_ADD;
    #1 chk("R9 old operand", mem_addr, 32'h0000_0100);
    tick();
    ctl_idle(); iord = 1;
    #1 chk("R9 new operand", mem_addr, 32'h0000_0100 + mr[13]);
    tick();

    chk("R3 all stores seen", exp_q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule